// File: doc/BRIEF.md
# Interleaved I/Q Sample Deinterleaver

This block sits at the front of a transmit path. One parallel bus carries I and Q samples in turn, one sample per data-clock cycle, and the block gathers them into I/Q pair words. A strobe input marks the cycle that carries the I sample, and the cycle after it carries the matching Q sample. When both have been seen, the block emits one 32-bit pair word with a valid pulse one cycle long. The word feeds a downstream FIFO.

The strobe's active level can be set. Flipping it makes the block treat the other sample of each couple as I, which gives spectral inversion without any other change. Capture can run free or can be gated by a transmit-enable input, and the enable's active level can also be set. The configuration pins are static: they are held steady while samples flow and are changed only between bursts.

The interface follows streaming rules with valid but no ready. The input carries a sample on every clock edge and cannot be stalled. The output cannot apply back-pressure either: the consumer must take every cycle in which `pair_valid` is high. The output always holds at least one idle cycle between pulses, so a consumer that accepts at most one word every other cycle can keep up.

Top module: `iq_deinterleaver`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pair_valid` is 0 and `pair_data` is 0 until the first pair is complete.
- R2: A sample taken with the strobe active, followed on the next edge by a sample with the strobe inactive, raises `pair_valid` in the cycle right after the second edge. `pair_data[31:16]` then holds the first sample (I) and `pair_data[15:0]` holds the second sample (Q).
- R3: `pair_valid` is high for exactly one cycle per pair. `pair_data` keeps the last pair until the next pair replaces it.
- R4: `cfg_width` holds the sample width minus one (0 means 1 bit, 15 means 16 bits). In both halves of `pair_data`, every bus bit above that position is zero.
- R5: With `cfg_strb_hi` = 1 the strobe is active when `strb` is high. With `cfg_strb_hi` = 0 it is active when `strb` is low.
- R6: A sample with the strobe inactive and no pending I sample is dropped and produces no pulse.
- R7: A strobe-active sample that arrives while an I sample is pending replaces the pending I. The next Q is paired with the newer I.
- R8: With `cfg_burst` = 0, `txen` has no effect on pairing or on the output.
- R9: With `cfg_burst` = 1, any cycle in which the enable is inactive produces no pulse and drops any pending I. A Q sample that arrives after such a gap does not pair.
- R10: With `cfg_en_hi` = 1 the enable is active when `txen` is high. With `cfg_en_hi` = 0 it is active when `txen` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; the bus is sampled on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Sample bus; the sample sits on the low bits |
| strb | input | 1 | Marks the I sample, at the level set by cfg_strb_hi |
| txen | input | 1 | Burst gate, at the level set by cfg_en_hi |
| cfg_width | input | 4 | Sample width minus one |
| cfg_strb_hi | input | 1 | 1: strobe active high; 0: strobe active low |
| cfg_en_hi | input | 1 | 1: enable active high; 0: enable active low |
| cfg_burst | input | 1 | 1: capture gated by txen; 0: free running |
| pair_data | output | 32 | I in bits 31:16, Q in bits 15:0 |
| pair_valid | output | 1 | One-cycle pulse per completed pair |

## Verification
The hardest case to reach is a pending I that must be dropped by a gap in the enable. To hit it, the stimulus has to drive an I sample with the gate open, close the gate for exactly one cycle, and then present a proper Q sample with the gate open again. Only the absence of a pulse after that Q shows that the half pair did not survive the gap. The restart case is reached in a similar way: the strobe is held active for two edges in a row, and the next pair must carry the second I.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
  localparam int SAMP_W = 16;
  localparam int CFGW_W = $clog2(SAMP_W);
  localparam int PAIR_W = 2 * SAMP_W;

  typedef logic [SAMP_W-1:0] samp_t;

  typedef struct packed {
    samp_t i_part;
    samp_t q_part;
  } pair_t;
endpackage

// File: rtl/iq_width_mask.sv
module iq_width_mask #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  raw,
  input  logic [CW-1:0] top_bit,
  output logic [W-1:0]  masked
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign masked[b] = raw[b] & (b <= int'(top_bit));
  end
endmodule

// File: rtl/iq_ctrl_decode.sv
module iq_ctrl_decode (
  input  logic strb,
  input  logic txen,
  input  logic strb_hi,
  input  logic en_hi,
  input  logic burst,
  output logic i_mark,
  output logic gate_open
);
  always_comb begin
    i_mark    = (strb == strb_hi);
    gate_open = !burst || (txen == en_hi);
  end
endmodule

// File: rtl/iq_pair_ctrl.sv
module iq_pair_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_mark,
  input  logic         gate_open,
  input  logic [W-1:0] samp,
  output logic [2*W-1:0] pair_data,
  output logic         pair_valid
);
  logic         have_i;
  logic [W-1:0] i_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_i     <= 1'b0;
      i_hold     <= '0;
      pair_data  <= '0;
      pair_valid <= 1'b0;
    end else if (!gate_open) begin
      have_i     <= 1'b0;
      pair_valid <= 1'b0;
    end else if (i_mark) begin
      have_i     <= 1'b1;
      i_hold     <= samp;
      pair_valid <= 1'b0;
    end else if (have_i) begin
      have_i     <= 1'b0;
      pair_data  <= {i_hold, samp};
      pair_valid <= 1'b1;
    end else begin
      pair_valid <= 1'b0;
    end
  end

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);
  p_data_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(pair_data));
  p_gate_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> !pair_valid);
  p_strobe_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && i_mark) |=> !pair_valid);
  p_q_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> pair_data[W-1:0] == $past(samp));
endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver
  import iq_deint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] din,
  input  logic              strb,
  input  logic              txen,
  input  logic [CFGW_W-1:0] cfg_width,
  input  logic              cfg_strb_hi,
  input  logic              cfg_en_hi,
  input  logic              cfg_burst,
  output logic [PAIR_W-1:0] pair_data,
  output logic              pair_valid
);
  samp_t samp_m;
  logic  i_mark;
  logic  gate_open;

  iq_width_mask #(.W(SAMP_W), .CW(CFGW_W)) u_mask (
    .raw(din), .top_bit(cfg_width), .masked(samp_m)
  );

  iq_ctrl_decode u_dec (
    .strb(strb), .txen(txen), .strb_hi(cfg_strb_hi), .en_hi(cfg_en_hi),
    .burst(cfg_burst), .i_mark(i_mark), .gate_open(gate_open)
  );

  iq_pair_ctrl #(.W(SAMP_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .i_mark(i_mark), .gate_open(gate_open),
    .samp(samp_m), .pair_data(pair_data), .pair_valid(pair_valid)
  );

  p_width_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ((({1'b0, pair_data[SAMP_W-1:0]}) >> ({1'b0, $past(cfg_width)} + 1'b1)) == '0)
                && ((({1'b0, pair_data[PAIR_W-1:SAMP_W]}) >> ({1'b0, $past(cfg_width)} + 1'b1)) == '0));
endmodule

// File: tb/sim_iq_deinterleaver.sv
module sim_iq_deinterleaver;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] d;
    logic        s;
    logic        e;
    logic        v;
    logic [31:0] q;
  } vec_t;

  // Width 16, strobe active high, free running (R2, R6, R7, R8)
  localparam vec_t TBL [8] = '{
    '{16'h1111, 1'b1, 1'b1, 1'b0, 32'h0},
    '{16'h2222, 1'b0, 1'b1, 1'b1, 32'h11112222},
    '{16'h3333, 1'b0, 1'b1, 1'b0, 32'h0},
    '{16'h4444, 1'b1, 1'b0, 1'b0, 32'h0},
    '{16'h5555, 1'b1, 1'b1, 1'b0, 32'h0},
    '{16'h6666, 1'b0, 1'b0, 1'b1, 32'h55556666},
    '{16'h7777, 1'b1, 1'b0, 1'b0, 32'h0},
    '{16'h8888, 1'b0, 1'b0, 1'b1, 32'h77778888}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] din = '0;
  logic strb = 1'b0, txen = 1'b0;
  logic [3:0] cfg_width = 4'd15;
  logic cfg_strb_hi = 1'b1, cfg_en_hi = 1'b1, cfg_burst = 1'b0;
  logic [31:0] pair_data;
  logic pair_valid;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  iq_deinterleaver u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .strb(strb), .txen(txen),
    .cfg_width(cfg_width), .cfg_strb_hi(cfg_strb_hi), .cfg_en_hi(cfg_en_hi),
    .cfg_burst(cfg_burst), .pair_data(pair_data), .pair_valid(pair_valid)
  );

  task automatic step(input logic [15:0] d, input logic s, input logic e);
    @(negedge clk);
    din = d; strb = s; txen = e;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ev, input logic cd, input logic [31:0] ed);
    total++;
    if (pair_valid !== ev || (cd && pair_data !== ed)) begin
      bad++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", req, pair_valid, pair_data, ev, ed);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    step(16'hFFFF, 1'b1, 1'b1);
    step(16'hEEEE, 1'b0, 1'b1);
    chk("R1", 1'b0, 1'b1, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    step(16'h0, 1'b0, 1'b1);
    chk("R1", 1'b0, 1'b1, 32'h0);

    // Table walk
    for (int k = 0; k < 8; k++) begin
      step(TBL[k].d, TBL[k].s, TBL[k].e);
      chk("R2/R6/R7/R8 table", TBL[k].v, TBL[k].v, TBL[k].q);
    end
    // R3: one-cycle pulse, data held
    step(16'h9999, 1'b0, 1'b1);
    chk("R3", 1'b0, 1'b1, 32'h77778888);

    // R4 width masking
    cfg_width = 4'd3;
    step(16'hABCD, 1'b1, 1'b1);
    step(16'h1234, 1'b0, 1'b1);
    chk("R4 width4", 1'b1, 1'b1, 32'h000D0004);
    cfg_width = 4'd0;
    step(16'hFFFF, 1'b1, 1'b1);
    step(16'hFFFE, 1'b0, 1'b1);
    chk("R4 width1", 1'b1, 1'b1, 32'h00010000);
    cfg_width = 4'd15;

    // R5 strobe active low: low marks I
    cfg_strb_hi = 1'b0;
    step(16'hAAAA, 1'b0, 1'b1);
    chk("R5 I cycle", 1'b0, 1'b0, 32'h0);
    step(16'hBBBB, 1'b1, 1'b1);
    chk("R5", 1'b1, 1'b1, 32'hAAAABBBB);
    cfg_strb_hi = 1'b1;

    // R9 burst gating drops pending I
    cfg_burst = 1'b1;
    step(16'h0101, 1'b1, 1'b1);
    step(16'h0202, 1'b0, 1'b0);
    chk("R9 gate closed", 1'b0, 1'b0, 32'h0);
    step(16'h0303, 1'b0, 1'b1);
    chk("R9 after gap", 1'b0, 1'b1, 32'hAAAABBBB);
    step(16'h0404, 1'b1, 1'b1);
    step(16'h0505, 1'b0, 1'b1);
    chk("R9 gate open", 1'b1, 1'b1, 32'h04040505);

    // R10 enable active low
    cfg_en_hi = 1'b0;
    step(16'h0606, 1'b1, 1'b0);
    step(16'h0707, 1'b0, 1'b0);
    chk("R10 low active", 1'b1, 1'b1, 32'h06060707);
    step(16'h0808, 1'b1, 1'b1);
    step(16'h0909, 1'b0, 1'b1);
    chk("R10 high inactive", 1'b0, 1'b1, 32'h06060707);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule